// File: doc/BRIEF.md
# GPIO expander register bank

This block is the register and command engine of a 24-pin GPIO expander that is reached over an I2C or SMBus target. A byte-level bus front end, outside this block, handles bit timing and address matching and hands over four kinds of events:

- a start or repeated start;
- a stop;
- each byte received in a write, with a strobe;
- for reads, a request for the next byte, then an indication that the host acknowledged that byte.

The first byte written after a start is a command byte. Its low seven bits name a register and its top bit turns on auto-increment. Auto-increment steps the pointer through the three port registers of one bank and then wraps back to the first.

Each 8-bit port has four registers: an input register that can only be read, an output value, a polarity-inversion mask and a direction mask. Each pin has one bit in each register. A pin whose direction bit is 0 is driven push-pull with its output bit XOR its polarity bit. A pin whose direction bit is 1 is left as a high-impedance input. Pin inputs pass through a two-flop synchronizer. Reading an input register returns the synchronized pins XOR the polarity mask.

An active-low interrupt flags any input-configured pin that now differs from the value captured when its port's input register was last read. That reference value is captured at the acknowledge of the read byte.

Top module: `gpio_xp_regbank`

## Requirements
- R1: After reset every direction bit is 1 (all output enables low), every output bit is 1, every polarity bit is 0 and `int_n` is high.
- R2: The output enable of each pin is the inverse of its direction bit. Direction registers sit at 0x0C, 0x0D and 0x0E for ports 0, 1 and 2.
- R3: Each driven pin value is the output bit XOR the polarity bit. Output registers sit at 0x04, 0x05 and 0x06, and polarity registers at 0x08, 0x09 and 0x0A.
- R4: A read of an input register (0x00, 0x01 or 0x02) returns the synchronized pin values XOR that port's polarity mask. Output-configured pins are included.
- R5: Bit 7 of the command byte enables auto-increment and bits 6:0 select the register. A read of a writable register returns the last value written to it.
- R6: With auto-increment off, every data byte after the command goes to the same register. The last byte wins.
- R7: With auto-increment on, write data bytes go to port 0, port 1 and port 2 of the selected bank in turn, then wrap to port 0.
- R8: With auto-increment on, successive read bytes cycle through the bank the same way. The pointer advances on each read acknowledge.
- R9: The register pointer survives a stop and a repeated start. A read issued without a new command byte uses the last command's register.
- R10: `int_n` goes low when an input-configured pin differs from its reference value. Changes on output-configured pins never assert it.
- R11: The acknowledge of a read byte from an input register loads that port's reference from the synchronized pins. This releases `int_n` for that port, and a later change asserts it again.
- R12: Writes to input registers or to unmapped addresses change nothing, and reads from unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Pulse on a start or repeated start |
| bus_stop | input | 1 | Pulse on a stop |
| rx_valid | input | 1 | Strobe for a received write byte |
| rx_data | input | 8 | Received write byte |
| rd_req | input | 1 | Request for the next read byte |
| rd_ack | input | 1 | Host acknowledged the read byte |
| rd_data | output | 8 | Read byte, registered on `rd_req` |
| pin_i | input | 24 | Raw pin inputs |
| pin_o | output | 24 | Pin drive values |
| pin_oe | output | 24 | Pin output enables (1 = driven) |
| int_n | output | 1 | Active-low change interrupt |

## Verification
The assertions check the following on every cycle:
- output enables move only on a received byte;
- the pointer holds still without auto-increment and wraps after the last port with it;
- an unmapped read yields zero;
- the reference of the read port matches the pins sampled at the acknowledge;
- a fully output-configured pin set never raises the interrupt.

Only the bench's scenarios can show the following:
- that values reach the intended register through the address map;
- that bytes repeated without auto-increment keep only the last;
- that the pointer survives a stop;
- that polarity reaches both the pins and the input read-back;
- that the interrupt falls, clears and rises again in the right order across real transactions.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  localparam int PORT_W = 8;

  // bank codes taken from register address bits 3:2
  localparam logic [1:0] BANK_IN  = 2'd0;
  localparam logic [1:0] BANK_OUT = 2'd1;
  localparam logic [1:0] BANK_POL = 2'd2;
  localparam logic [1:0] BANK_DIR = 2'd3;

  typedef struct packed {
    logic       valid;
    logic [1:0] bank;
    logic [1:0] port;
  } reg_sel_t;

  // split a 7-bit register address into bank and port; last = highest port index
  function automatic reg_sel_t gpx_decode(input logic [6:0] a, input logic [1:0] last);
    reg_sel_t s;
    s.valid = (a[6:4] == 3'd0) && (a[1:0] <= last);
    s.bank  = a[3:2];
    s.port  = a[1:0];
    return s;
  endfunction

  // auto-increment: advance the port field, wrapping inside the bank
  function automatic logic [6:0] gpx_step(input logic [6:0] a, input logic [1:0] last);
    logic [1:0] nxt;
    nxt = (a[1:0] >= last) ? 2'd0 : a[1:0] + 2'd1;
    return {a[6:2], nxt};
  endfunction

  // polarity applied to a byte in either direction
  function automatic logic [PORT_W-1:0] gpx_pol(input logic [PORT_W-1:0] v,
                                                input logic [PORT_W-1:0] p);
    return v ^ p;
  endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpx_cmd.sv
module gpx_cmd
  import gpx_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rd_ack,
  output logic [6:0] ptr,
  output logic       ai,
  output logic       wr_evt
);
  localparam logic [1:0] LAST = 2'(NPORT - 1);

  logic want_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      ai       <= 1'b0;
      want_cmd <= 1'b1;
    end else begin
      if (bus_start || bus_stop) want_cmd <= 1'b1;
      if (rx_valid) begin
        if (want_cmd) begin
          ptr      <= rx_data[6:0];
          ai       <= rx_data[7];
          want_cmd <= 1'b0;
        end else if (ai) begin
          ptr <= gpx_step(ptr, LAST);
        end
      end else if (rd_ack && ai) begin
        ptr <= gpx_step(ptr, LAST);
      end
    end
  end

  // a data byte (not the command byte) lands in a register this cycle
  assign wr_evt = rx_valid && !want_cmd;
endmodule

// File: rtl/gpx_port.sv
module gpx_port
  import gpx_pkg::*;
#(
  parameter int PW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          wr_en,
  input  logic [1:0]    wr_bank,
  input  logic [PW-1:0] wr_data,
  input  logic          snap,
  input  logic [PW-1:0] sync_in,
  input  logic [1:0]    rd_bank,
  output logic [PW-1:0] rd_byte,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe,
  output logic [PW-1:0] ref_q,
  output logic          chg
);
  logic [PW-1:0] out_q, pol_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      pol_q <= '0;
      dir_q <= '1;
      ref_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_bank)
          BANK_OUT: out_q <= wr_data;
          BANK_POL: pol_q <= wr_data;
          BANK_DIR: dir_q <= wr_data;
          default:  ;
        endcase
      end
      if (!armed || snap) ref_q <= sync_in;
    end
  end

  always_comb begin
    case (rd_bank)
      BANK_IN:  rd_byte = gpx_pol(sync_in, pol_q);
      BANK_OUT: rd_byte = out_q;
      BANK_POL: rd_byte = pol_q;
      default:  rd_byte = dir_q;
    endcase
  end

  assign pin_o  = gpx_pol(out_q, pol_q);
  assign pin_oe = ~dir_q;
  assign chg    = |((sync_in ^ ref_q) & dir_q);
endmodule

// File: rtl/gpio_xp_regbank.sv
module gpio_xp_regbank
  import gpx_pkg::*;
#(
  parameter int NPORT       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_start,
  input  logic                    bus_stop,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rd_req,
  input  logic                    rd_ack,
  output logic [7:0]              rd_data,
  input  logic [NPORT*PORT_W-1:0] pin_i,
  output logic [NPORT*PORT_W-1:0] pin_o,
  output logic [NPORT*PORT_W-1:0] pin_oe,
  output logic                    int_n
);
  localparam int         PW      = PORT_W;
  localparam int         NPIN    = NPORT * PW;
  localparam int         SLOTS   = 4;
  localparam logic [1:0] LAST    = 2'(NPORT - 1);
  localparam logic [1:0] ARM_CYC = 2'(SYNC_STAGES + 1);

  // named internal events, also used by the checker
  logic [6:0]      ptr;
  logic            ai;
  logic            wr_evt;
  reg_sel_t        sel;
  logic            ptr_valid;
  logic [NPIN-1:0] sync_flat;
  logic [NPIN-1:0] ref_flat;
  logic [NPIN-1:0] ack_mask;
  logic            ack_in_evt;
  logic            armed;

  logic [1:0]      arm_cnt;
  logic [NPORT-1:0] snap_v;
  logic [NPORT-1:0] chg_v;
  logic [PW-1:0]   rd_bytes [SLOTS];

  gpx_cmd #(.NPORT(NPORT)) u_cmd (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .rd_ack(rd_ack),
    .ptr(ptr), .ai(ai), .wr_evt(wr_evt)
  );

  gpx_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sync_flat)
  );

  assign sel       = gpx_decode(ptr, LAST);
  assign ptr_valid = sel.valid;

  // references follow the pins until the synchronizer is filled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        arm_cnt <= '0;
    else if (!armed)   arm_cnt <= arm_cnt + 2'd1;
  end
  assign armed = (arm_cnt == ARM_CYC);

  for (genvar g = 0; g < SLOTS; g++) begin : g_port
    if (g < NPORT) begin : g_live
      localparam logic [1:0] IDX = 2'(g);
      logic hit;
      assign hit      = sel.valid && (sel.port == IDX);
      assign snap_v[g] = rd_ack && hit && (sel.bank == BANK_IN);
      assign ack_mask[g*PW +: PW] = {PW{snap_v[g]}};

      gpx_port #(.PW(PW)) u_port (
        .clk(clk), .rst_n(rst_n), .armed(armed),
        .wr_en(wr_evt && hit && (sel.bank != BANK_IN)),
        .wr_bank(sel.bank), .wr_data(rx_data),
        .snap(snap_v[g]), .sync_in(sync_flat[g*PW +: PW]),
        .rd_bank(sel.bank), .rd_byte(rd_bytes[g]),
        .pin_o(pin_o[g*PW +: PW]), .pin_oe(pin_oe[g*PW +: PW]),
        .ref_q(ref_flat[g*PW +: PW]), .chg(chg_v[g])
      );
    end else begin : g_idle
      assign rd_bytes[g] = '0;
    end
  end

  assign ack_in_evt = |snap_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= sel.valid ? rd_bytes[sel.port] : '0;
  end

  assign int_n = ~(armed && (|chg_v));
endmodule

// File: rtl/gpx_regbank_chk.sv
module gpx_regbank_chk #(
  parameter int NPORT = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_valid,
  input logic                 rd_req,
  input logic [7:0]           rd_data,
  input logic [NPORT*8-1:0]   pin_oe,
  input logic                 int_n,
  input logic [6:0]           ptr,
  input logic                 ai,
  input logic                 wr_evt,
  input logic                 ptr_valid,
  input logic                 ack_in_evt,
  input logic [NPORT*8-1:0]   ack_mask,
  input logic [NPORT*8-1:0]   ref_flat,
  input logic [NPORT*8-1:0]   sync_flat
);
  localparam logic [1:0] LAST = 2'(NPORT - 1);

  p_rst_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && int_n));

  p_oe_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(pin_oe));

  p_no_ai_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !ai) |=> $stable(ptr));

  p_ai_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ai && ptr[1:0] == LAST) |=> (ptr[1:0] == 2'd0));

  p_quiet_when_driven_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == '1) |-> int_n);

  p_ref_loaded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_in_evt |=> (((ref_flat ^ $past(sync_flat)) & $past(ack_mask)) == '0));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !ptr_valid) |=> (rd_data == 8'h00));
endmodule

bind gpio_xp_regbank gpx_regbank_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/sim_gpio_xp_regbank.sv
module sim_gpio_xp_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rd_req = 1'b0, rd_ack = 1'b0;
  logic [7:0]  rd_data;
  logic [23:0] pin_i = 24'h5AA5C3;
  logic [23:0] pin_o, pin_oe;
  logic        int_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_xp_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
  );

  // {register address, data written, value expected on read-back}
  localparam logic [23:0] VEC [9] = '{
    {8'h04, 8'h3C, 8'h3C},   // R5 output port 0
    {8'h05, 8'hA1, 8'hA1},   // R5 output port 1
    {8'h0A, 8'h0F, 8'h0F},   // R3 polarity port 2
    {8'h0D, 8'h00, 8'h00},   // R2 port 1 all outputs
    {8'h07, 8'h55, 8'h00},   // R12 unmapped slot in bank
    {8'h10, 8'h77, 8'h00},   // R12 beyond map
    {8'h00, 8'h99, 8'hC3},   // R12 input write ignored, R4 pins C3
    {8'h02, 8'h11, 8'h55},   // R4 pins 5A xor polarity 0F
    {8'h0E, 8'hF0, 8'hF0}    // R2 port 2 low nibble outputs
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_start(); bus_start = 1'b1; @(negedge clk); bus_start = 1'b0; endtask
  task automatic do_stop();  bus_stop  = 1'b1; @(negedge clk); bus_stop  = 1'b0; endtask

  task automatic send(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic fetch(output logic [7:0] v);
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    v = rd_data;
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] d);
    do_start(); send(cmd); send(d); do_stop();
  endtask

  task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] v);
    do_start(); send(cmd); do_start(); fetch(v); do_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    check("R1 oe", 32'(pin_oe), 32'h000000);
    check("R1 pin_o", 32'(pin_o), 32'hFFFFFF);
    check("R1 int_n", 32'(int_n), 32'h1);
    rd_reg(8'h0C, v); check("R1 dir0", 32'(v), 32'hFF);

    // vector table
    foreach (VEC[i]) begin
      wr_reg(VEC[i][23:16], VEC[i][15:8]);
      rd_reg(VEC[i][23:16], v);
      check($sformatf("R5/R12 vec %0d addr %h", i, VEC[i][23:16]), 32'(v), 32'(VEC[i][7:0]));
    end

    // direction and polarity at the pins
    check("R2 oe", 32'(pin_oe), 32'h0FFF00);
    check("R3 pin_o", 32'(pin_o), 32'hF0A13C);

    // R6 repeated bytes without auto-increment
    do_start(); send(8'h04); send(8'h11); send(8'h22); send(8'h33); do_stop();
    rd_reg(8'h04, v); check("R6 last wins", 32'(v), 32'h33);
    rd_reg(8'h05, v); check("R6 neighbour kept", 32'(v), 32'hA1);

    // R7 auto-increment write wraps
    do_start(); send(8'h84); send(8'h01); send(8'h02); send(8'h03); send(8'h04); do_stop();
    rd_reg(8'h04, v); check("R7 port0 wrapped", 32'(v), 32'h04);
    rd_reg(8'h05, v); check("R7 port1", 32'(v), 32'h02);
    rd_reg(8'h06, v); check("R7 port2", 32'(v), 32'h03);

    // R8 auto-increment read cycles
    do_start(); send(8'h84); do_start();
    fetch(v); check("R8 byte0", 32'(v), 32'h04);
    fetch(v); check("R8 byte1", 32'(v), 32'h02);
    fetch(v); check("R8 byte2", 32'(v), 32'h03);
    fetch(v); check("R8 byte3 wrap", 32'(v), 32'h04);
    do_stop();

    // R9 pointer kept across a stop
    do_start(); send(8'h05); do_stop();
    do_start(); fetch(v); do_stop();
    check("R9 kept pointer", 32'(v), 32'h02);

    // R10 output-pin changes ignored, input changes flagged
    check("R10 idle", 32'(int_n), 32'h1);
    pin_i[15:8] = ~pin_i[15:8];
    repeat (4) @(negedge clk);
    check("R10 output pins quiet", 32'(int_n), 32'h1);
    pin_i[0] = ~pin_i[0];
    repeat (4) @(negedge clk);
    check("R10 input change", 32'(int_n), 32'h0);

    // R11 clear on input read, set again on a later change
    rd_reg(8'h00, v);
    check("R11 read value", 32'(v), 32'hC2);
    check("R11 cleared", 32'(int_n), 32'h1);
    pin_i[20] = ~pin_i[20];
    repeat (4) @(negedge clk);
    check("R11 re-asserted", 32'(int_n), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule